// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit sits between an execute stage and a single-port memory that answers each access with an acknowledge. It takes one request at a time, reads the addressed 64-bit word, computes a new value for an 8-, 16-, 32- or 64-bit lane inside that word, and writes the lane back. The memory is not released between the read and the write. The original lane value always comes back to the execute stage, together with a zero/success flag and, for the bit operations, the state the bit had before the operation.

Each request is a full barrier. The unit accepts a request only when the execute stage reports that all earlier memory traffic has drained, and only when the unit itself is idle. A lane that does not sit on a multiple of its own size is rejected. In that case the unit makes no memory access and completes with a fault flag.

Top module: `amo_unit`

## Requirements
- R1: The opcode selects the operation: 0 fetch-add, 1 fetch-sub, 2 fetch-and, 3 fetch-or, 4 test-and-set bit, 5 test-and-clear bit, 6 compare-exchange, 7 swap. The value written back is the result of that operation applied to the old lane and the operand.
- R2: When `done` is high, `old_value` holds the lane's prior memory contents, zero-extended to 64 bits.
- R3: `bus_lock` is high in every cycle that `mem_req` is high. It stays high continuously from the first read-request cycle through the cycle of the write acknowledge.
- R4: `done` is a one-cycle pulse. With a memory that acknowledges after L wait cycles, it rises 2L+3 cycles after the accepting clock edge when a write happens. It rises L+2 cycles after that edge when compare-exchange skips its write.
- R5: Compare-exchange writes the operand only when the old lane equals `req_cmp` masked to the lane width. `z_flag` is 1 on success and 0 on failure. A failed compare makes no write access.
- R6: For opcodes 4 and 5, the bit index is the operand modulo the lane width. `bit_was_set` reports the bit's prior value and `z_flag` is its inverse. For all other opcodes `bit_was_set` is 0.
- R7: `req_size` encodes 0=8, 1=16, 2=32, 3=64 bits. Byte address bits [2:0] give the lowest byte of the lane, with byte 0 in data bits [7:0]. `mem_be` enables only the lane's bytes, and the other bytes of the word are left unchanged.
- R8: A request whose address is not a multiple of the lane size in bytes makes no memory access. It completes with `done` in the cycle after acceptance, `fault` = 1, and zero `old_value`, `z_flag` and `bit_was_set`.
- R9: `req_ready` is low while `prior_quiet` is low and while an operation is in progress. A request is taken only on a clock edge where `req_valid` and `req_ready` are both high.
- R10: Arithmetic wraps within the lane width. For opcodes 0, 1, 2, 3 and 7, `z_flag` is 1 exactly when the written lane value is zero.
- R11: After reset the unit is idle: `mem_req`, `bus_lock` and `done` are low, and `req_ready` follows `prior_quiet`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this edge |
| req_op | input | 3 | Operation code |
| req_size | input | 2 | Lane size code |
| req_addr | input | ADDR_W | Byte address |
| req_opnd | input | 64 | Operand / new value / bit index |
| req_cmp | input | 64 | Compare value for compare-exchange |
| prior_quiet | input | 1 | All earlier memory accesses finished |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W-3 | Word address |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Access acknowledge, read data valid |
| mem_rdata | input | 64 | Read data |
| bus_lock | output | 1 | Memory held for this unit |
| done | output | 1 | Completion pulse |
| old_value | output | 64 | Prior lane contents |
| z_flag | output | 1 | Zero / success flag |
| bit_was_set | output | 1 | Prior state of the tested bit |
| fault | output | 1 | Misaligned request |

## Verification
Every opcode is tried against a model that holds its own copy of memory, across all four lane sizes and at low, middle and top byte positions. This separates correct lane placement and byte enables from errors that only show with full-word access. The wait states of the memory acknowledge vary from zero to three, and the lock and done timing are compared cycle by cycle, so a lock that drops between the read and the write or a completion pulse that arrives early is caught. Paired cases tell the flag paths apart: a bit set twice, a compare that matches and then fails, sums and swaps that produce zero, and misaligned addresses. A request held while the drain input is low shows whether the barrier gate works.

// File: rtl/amo_pkg.sv
package amo_pkg;
    localparam int unsigned WORD_W     = 64;
    localparam int unsigned LANE_N     = WORD_W / 8;
    localparam int unsigned LANE_IDX_W = $clog2(LANE_N);
    localparam int unsigned BIT_IDX_W  = $clog2(WORD_W);

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_BSET = 3'd4,
        OP_BCLR = 3'd5,
        OP_CAS  = 3'd6,
        OP_SWAP = 3'd7
    } amo_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } amo_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } amo_state_e;

    typedef struct packed {
        amo_op_e                 op;
        amo_size_e               size;
        logic [LANE_IDX_W-1:0]   lane;
        logic [WORD_W-1:0]       opnd;
        logic [WORD_W-1:0]       cmp;
    } amo_cmd_t;

    typedef struct packed {
        logic [WORD_W-1:0] new_val;
        logic              do_write;
        logic              z;
        logic              bit_prior;
    } amo_res_t;

    function automatic logic [WORD_W-1:0] width_mask(amo_size_e sz);
        case (sz)
            SZ_8:    return WORD_W'(8'hFF);
            SZ_16:   return WORD_W'(16'hFFFF);
            SZ_32:   return WORD_W'(32'hFFFF_FFFF);
            default: return '1;
        endcase
    endfunction

    function automatic logic [LANE_N-1:0] byte_span(amo_size_e sz);
        case (sz)
            SZ_8:    return LANE_N'(1);
            SZ_16:   return LANE_N'(3);
            SZ_32:   return LANE_N'(15);
            default: return '1;
        endcase
    endfunction

    function automatic logic [BIT_IDX_W-1:0] bit_limit(amo_size_e sz);
        case (sz)
            SZ_8:    return BIT_IDX_W'(7);
            SZ_16:   return BIT_IDX_W'(15);
            SZ_32:   return BIT_IDX_W'(31);
            default: return '1;
        endcase
    endfunction

    function automatic logic lane_misaligned(amo_size_e sz, logic [LANE_IDX_W-1:0] lane);
        case (sz)
            SZ_8:    return 1'b0;
            SZ_16:   return lane[0];
            SZ_32:   return |lane[1:0];
            default: return |lane;
        endcase
    endfunction
endpackage

// File: rtl/amo_lane.sv
module amo_lane
    import amo_pkg::*;
(
    input  amo_size_e               size_i,
    input  logic [LANE_IDX_W-1:0]   lane_i,
    input  logic [WORD_W-1:0]       rword_i,
    input  logic [WORD_W-1:0]       lane_val_i,
    output logic [WORD_W-1:0]       lane_old_o,
    output logic [WORD_W-1:0]       wword_o,
    output logic [LANE_N-1:0]       be_o
);
    localparam int unsigned SHIFT_W = LANE_IDX_W + 3;

    logic [SHIFT_W-1:0]  shamt;
    logic [WORD_W-1:0]   mask;
    logic [LANE_N-1:0]   span;

    assign shamt = {lane_i, 3'b000};
    assign mask  = width_mask(size_i);
    assign span  = byte_span(size_i);

    assign lane_old_o = (rword_i >> shamt) & mask;
    assign wword_o    = (lane_val_i & mask) << shamt;

    // one enable per byte position: set when the byte lies inside the lane
    for (genvar g = 0; g < LANE_N; g++) begin : g_be
        logic [LANE_IDX_W:0] rel;
        assign rel     = (LANE_IDX_W+1)'(g) - {1'b0, lane_i};
        assign be_o[g] = (g >= int'(lane_i)) && span[rel[LANE_IDX_W-1:0]] && !rel[LANE_IDX_W];
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
(
    input  amo_cmd_t            cmd_i,
    input  logic [WORD_W-1:0]   old_i,
    output amo_res_t            res_o
);
    logic [WORD_W-1:0]    mask;
    logic [WORD_W-1:0]    src;
    logic [WORD_W-1:0]    cmpv;
    logic [BIT_IDX_W-1:0] idx;
    logic [WORD_W-1:0]    bitv;
    logic                 prior;
    logic [WORD_W-1:0]    nv;
    logic                 match;

    always_comb begin
        mask  = width_mask(cmd_i.size);
        src   = cmd_i.opnd & mask;
        cmpv  = cmd_i.cmp & mask;
        idx   = cmd_i.opnd[BIT_IDX_W-1:0] & bit_limit(cmd_i.size);
        bitv  = WORD_W'(1) << idx;
        prior = old_i[idx];
        match = (old_i == cmpv);
        nv    = '0;
        res_o = '0;
        res_o.do_write = 1'b1;
        case (cmd_i.op)
            OP_ADD:  nv = (old_i + src) & mask;
            OP_SUB:  nv = (old_i - src) & mask;
            OP_AND:  nv = old_i & src;
            OP_OR:   nv = old_i | src;
            OP_BSET: nv = old_i | bitv;
            OP_BCLR: nv = old_i & ~bitv;
            OP_CAS:  nv = src;
            default: nv = src;
        endcase
        res_o.new_val = nv;
        case (cmd_i.op)
            OP_BSET, OP_BCLR: begin
                res_o.z         = ~prior;
                res_o.bit_prior = prior;
            end
            OP_CAS: begin
                res_o.z        = match;
                res_o.do_write = match;
            end
            default: res_o.z = (nv == '0);
        endcase
    end
endmodule

// File: rtl/amo_fsm.sv
module amo_fsm
    import amo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       quiet_i,
    input  logic       misalign_i,
    input  logic       write_needed_i,
    input  logic       mem_ack_i,
    output logic       ready_o,
    output logic       accept_o,
    output logic       rd_ack_o,
    output logic       mem_req_o,
    output logic       mem_we_o,
    output logic       lock_o,
    output logic       done_o
);
    amo_state_e state_q, state_d;

    assign ready_o  = (state_q == ST_IDLE) && quiet_i;
    assign accept_o = ready_o && start_i;
    assign rd_ack_o = (state_q == ST_READ) && mem_ack_i;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (accept_o) state_d = misalign_i ? ST_DONE : ST_READ;
            ST_READ:  if (mem_ack_i) state_d = write_needed_i ? ST_WRITE : ST_DONE;
            ST_WRITE: if (mem_ack_i) state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign mem_req_o = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign mem_we_o  = (state_q == ST_WRITE);
    assign lock_o    = mem_req_o;
    assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [2:0]                req_op,
    input  logic [1:0]                req_size,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [63:0]               req_opnd,
    input  logic [63:0]               req_cmp,
    input  logic                      prior_quiet,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-4:0]         mem_addr,
    output logic [7:0]                mem_be,
    output logic [63:0]               mem_wdata,
    input  logic                      mem_ack,
    input  logic [63:0]               mem_rdata,
    output logic                      bus_lock,
    output logic                      done,
    output logic [63:0]               old_value,
    output logic                      z_flag,
    output logic                      bit_was_set,
    output logic                      fault
);
    localparam int unsigned WADDR_W = ADDR_W - LANE_IDX_W;

    amo_cmd_t            cmd_in, cmd_q;
    amo_res_t            alu_res, res_q;
    logic [WADDR_W-1:0]  waddr_q;
    logic [WORD_W-1:0]   old_q;
    logic                fault_q;
    logic                misalign;
    logic                accept, rd_ack;
    logic [WORD_W-1:0]   lane_old;

    always_comb begin
        cmd_in.op   = amo_op_e'(req_op);
        cmd_in.size = amo_size_e'(req_size);
        cmd_in.lane = req_addr[LANE_IDX_W-1:0];
        cmd_in.opnd = req_opnd;
        cmd_in.cmp  = req_cmp;
    end

    assign misalign = lane_misaligned(cmd_in.size, cmd_in.lane);

    amo_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .start_i        (req_valid),
        .quiet_i        (prior_quiet),
        .misalign_i     (misalign),
        .write_needed_i (alu_res.do_write),
        .mem_ack_i      (mem_ack),
        .ready_o        (req_ready),
        .accept_o       (accept),
        .rd_ack_o       (rd_ack),
        .mem_req_o      (mem_req),
        .mem_we_o       (mem_we),
        .lock_o         (bus_lock),
        .done_o         (done)
    );

    amo_lane u_lane (
        .size_i     (cmd_q.size),
        .lane_i     (cmd_q.lane),
        .rword_i    (mem_rdata),
        .lane_val_i (res_q.new_val),
        .lane_old_o (lane_old),
        .wword_o    (mem_wdata),
        .be_o       (mem_be)
    );

    amo_alu u_alu (
        .cmd_i (cmd_q),
        .old_i (lane_old),
        .res_o (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            res_q   <= '0;
            waddr_q <= '0;
            old_q   <= '0;
            fault_q <= 1'b0;
        end else if (accept) begin
            cmd_q   <= cmd_in;
            waddr_q <= req_addr[ADDR_W-1:LANE_IDX_W];
            fault_q <= misalign;
            res_q   <= '0;
            old_q   <= '0;
        end else if (rd_ack) begin
            res_q   <= alu_res;
            old_q   <= lane_old;
        end
    end

    assign mem_addr    = waddr_q;
    assign old_value   = old_q;
    assign z_flag      = res_q.z;
    assign bit_was_set = res_q.bit_prior;
    assign fault       = fault_q;
endmodule

// File: rtl/amo_chk.sv
module amo_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       prior_quiet,
    input logic       mem_req,
    input logic       mem_we,
    input logic [7:0] mem_be,
    input logic       bus_lock,
    input logic       done,
    input logic       fault
);
    AST_LOCK_COVERS_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> bus_lock); // R3
    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> $past(bus_lock)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4
    AST_FAULT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> !$past(mem_req)); // R8
    AST_BE_LANE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                     $countones(mem_be) == 4 || $countones(mem_be) == 8)); // R7
    AST_TAKE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> prior_quiet); // R9
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        bus_lock |-> !req_ready); // R9
endmodule

bind amo_unit amo_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .prior_quiet (prior_quiet),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_be      (mem_be),
    .bus_lock    (bus_lock),
    .done        (done),
    .fault       (fault)
);

// File: tb/sim_amo_unit.sv
module sim_amo_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [2:0]  req_op;
    logic [1:0]  req_size;
    logic [15:0] req_addr;
    logic [63:0] req_opnd;
    logic [63:0] req_cmp;
    logic        prior_quiet;
    logic        mem_req, mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic        mem_ack;
    logic [63:0] mem_rdata;
    logic        bus_lock, done, z_flag, bit_was_set, fault;
    logic [63:0] old_value;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] mem [16];
    int lat = 0;
    int wcnt = 0;
    int wr_count = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amo_unit #(.ADDR_W(16)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_size(req_size), .req_addr(req_addr),
        .req_opnd(req_opnd), .req_cmp(req_cmp), .prior_quiet(prior_quiet),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .bus_lock(bus_lock), .done(done), .old_value(old_value), .z_flag(z_flag),
        .bit_was_set(bit_was_set), .fault(fault)
    );

    // memory model: acknowledges after lat wait cycles, updated away from the edge
    always @(negedge clk) begin
        if (rst || !mem_req) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (wcnt == lat) begin
            mem_ack = 1'b1;
            wcnt = 0;
            mem_rdata = mem[mem_addr[3:0]];
            if (mem_we) begin
                for (int b = 0; b < 8; b++)
                    if (mem_be[b]) mem[mem_addr[3:0]][b*8 +: 8] = mem_wdata[b*8 +: 8];
                wr_count++;
            end
        end else begin
            mem_ack = 1'b0;
            wcnt++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void ref_op(input logic [2:0] op, input logic [1:0] sz,
                                   input logic [15:0] addr, input logic [63:0] opnd,
                                   input logic [63:0] cmp, input logic [63:0] word,
                                   output logic [63:0] old, output logic [63:0] nword,
                                   output bit z, output bit bp, output bit wr, output bit flt);
        int nb, w, ln, bi;
        logic [63:0] m, s, c, n;
        nb = 1 << sz;
        w  = nb * 8;
        ln = int'(addr[2:0]);
        flt = (ln % nb) != 0;
        old = 0; nword = word; z = 0; bp = 0; wr = 0;
        if (flt) return;
        m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        old = (word >> (ln * 8)) & m;
        s = opnd & m;
        c = cmp & m;
        bi = int'(opnd[5:0]) % w;
        wr = 1;
        case (op)
            3'd0: n = (old + s) & m;
            3'd1: n = (old - s) & m;
            3'd2: n = old & s;
            3'd3: n = old | s;
            3'd4: n = old | (64'd1 << bi);
            3'd5: n = old & ~(64'd1 << bi);
            3'd6: begin n = s; wr = (old == c); end
            default: n = s;
        endcase
        if (op == 3'd4 || op == 3'd5) begin
            bp = old[bi];
            z = !old[bi];
        end else if (op == 3'd6) z = (old == c);
        else z = (n == 0);
        if (wr) nword = (word & ~(m << (ln * 8))) | (n << (ln * 8));
    endfunction

    task automatic run(input logic [2:0] op, input logic [1:0] sz, input logic [15:0] addr,
                       input logic [63:0] opnd, input logic [63:0] cmp, input int l,
                       input string tag);
        logic [63:0] eold, enew;
        bit ez, ebp, ewr, eflt;
        int fin, lock_end, wc0, idx;
        idx = int'(addr[6:3]);
        ref_op(op, sz, addr, opnd, cmp, mem[idx], eold, enew, ez, ebp, ewr, eflt);
        fin      = eflt ? 1 : (ewr ? 2*l + 3 : l + 2);
        lock_end = eflt ? 0 : (ewr ? 2*l + 2 : l + 1);
        @(negedge clk);
        lat = l;
        wc0 = wr_count;
        req_op = op; req_size = sz; req_addr = addr; req_opnd = opnd; req_cmp = cmp;
        req_valid = 1'b1;
        chk("R9 ready when idle", 64'(req_ready), 64'd1);
        for (int k = 1; k <= fin; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            chk("R3 lock window", 64'(bus_lock), 64'(k <= lock_end));
            chk("R4 done timing", 64'(done), 64'(k == fin));
            chk("R9 busy not ready", 64'(req_ready), 64'd0);
        end
        chk("R2 old value", old_value, eold);
        chk({tag, " z flag"}, 64'(z_flag), 64'(ez));
        chk("R6 prior bit", 64'(bit_was_set), 64'(ebp));
        chk("R8 fault", 64'(fault), 64'(eflt));
        chk({tag, " memory word"}, mem[idx], enew);
        chk("R5 write count", 64'(wr_count - wc0), 64'(ewr));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] cur;
        for (int i = 0; i < 16; i++)
            mem[i] = {32'hA5C3_7100 + 32'(i * 37), 32'h1357_9BDF ^ 32'(i << 9)};
        mem_ack = 1'b0; mem_rdata = '0;
        rst = 1'b1; prior_quiet = 1'b1; req_valid = 1'b0;
        req_op = '0; req_size = '0; req_addr = '0; req_opnd = '0; req_cmp = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 ready", 64'(req_ready), 64'd1);
        chk("R11 mem_req", 64'(mem_req), 64'd0);
        chk("R11 lock", 64'(bus_lock), 64'd0);
        chk("R11 done", 64'(done), 64'd0);
        rst = 1'b0;

        run(3'd0, 2'd3, 16'h0008, 64'h5, 64'h0, 0, "R1 add64");
        run(3'd1, 2'd0, 16'h0013, 64'hF0, 64'h0, 1, "R10 sub8 wrap");
        run(3'd2, 2'd1, 16'h001A, 64'hFF0F_0F0F, 64'h0, 2, "R7 and16");
        run(3'd3, 2'd2, 16'h0024, 64'h8000_0001, 64'h0, 1, "R1 or32");
        run(3'd4, 2'd0, 16'h0015, 64'd11, 64'h0, 0, "R6 bset first");
        run(3'd4, 2'd0, 16'h0015, 64'd11, 64'h0, 0, "R6 bset again");
        run(3'd4, 2'd0, 16'h000F, 64'd7, 64'h0, 1, "R7 top byte");
        run(3'd5, 2'd2, 16'h002C, 64'd36, 64'h0, 1, "R6 bclr first");
        run(3'd5, 2'd2, 16'h002C, 64'd36, 64'h0, 1, "R6 bclr again");
        cur = (mem[7] >> 16) & 64'hFFFF;
        run(3'd6, 2'd1, 16'h003A, 64'hBEEF, cur, 1, "R5 cas match");
        run(3'd6, 2'd1, 16'h003A, 64'h1234, 64'h1111, 2, "R5 cas miss");
        run(3'd7, 2'd3, 16'h0040, 64'hDEAD_BEEF_0BAD_F00D, 64'h0, 3, "R1 swap64");
        run(3'd7, 2'd2, 16'h0048, 64'h0, 64'h0, 0, "R10 swap zero");
        cur = (mem[10] >> 8) & 64'hFF;
        run(3'd0, 2'd0, 16'h0051, (64'h100 - cur) & 64'hFF, 64'h0, 1, "R10 add to zero");
        run(3'd0, 2'd2, 16'h0022, 64'h1, 64'h0, 0, "R8 mis32");
        run(3'd7, 2'd3, 16'h0031, 64'h55, 64'h0, 2, "R8 mis64");
        run(3'd1, 2'd1, 16'h000B, 64'h3, 64'h0, 0, "R8 mis16");

        // barrier: request held while earlier traffic has not drained
        @(negedge clk);
        prior_quiet = 1'b0;
        req_op = 3'd0; req_size = 2'd3; req_addr = 16'h0060; req_opnd = 64'h1;
        req_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9 not ready while draining", 64'(req_ready), 64'd0);
            chk("R9 no access while draining", 64'(mem_req), 64'd0);
        end
        req_valid = 1'b0;
        prior_quiet = 1'b1;
        run(3'd0, 2'd3, 16'h0060, 64'h1, 64'h0, 1, "R9 after drain");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule